// File: doc/BRIEF.md
# Multi-Mode Interval Timer

A free-running interval timer for a small controller subsystem. A counter of up to 16 bits advances on ticks taken from one of four clock-enable inputs, after an optional power-of-two divider. One period register bounds the count in two of its three counting modes: a sawtooth that restarts at zero after reaching the period, a free-run mode that wraps at the counter's full scale, and a symmetric triangle that climbs to the period and descends back to zero. Each completed cycle raises a sticky pending flag, and the interrupt request is that flag gated by an enable bit.

Software reaches the block through a simple synchronous register bus with three word locations: control, count and period. Source, divider, mode, interrupt enable, pending flag and a self-clearing restart bit are all packed in the control word. The counting engine is a three-state machine. `ST_IDLE` is held while the mode is stop. `ST_RISE` counts upward. `ST_FALL` counts downward and is used only in triangle mode. The transitions are: IDLE to RISE when a running mode is selected; RISE or FALL to IDLE when stop is selected; RISE to FALL when the triangle turns at the period; FALL to RISE when the count reaches zero or the mode leaves triangle; and any state to RISE on a restart.

Top module: `multimode_timer`

## Requirements
- R1: After reset the control word, count and period all read 0 and `irq` is low.
- R2: Control bits 9:8 select the tick source. 00 selects `tick_ext`, 01 selects `tick_aux`, 10 selects `tick_sys` and 11 selects `tick_ext_n`. Pulses on the three unselected inputs leave the count unchanged.
- R3: Control bits 7:6 set the divider. The count advances once per 1, 2, 4 or 8 selected ticks for codes 0 to 3, and the first advance after a restart falls on the N-th tick.
- R4: Control bits 5:4 = 00 (stop) hold the count through any number of ticks.
- R5: With mode 01 (up) and period P > 0, the count runs 0, 1, …, P, 0 and so on. The flag sets on each step from a value at or above P back to 0, so a count above P returns to 0 on the next advance.
- R6: With mode 10 (continuous), the count runs to all ones (2^CNT_W − 1) and wraps to 0. The flag sets on that wrap.
- R7: With mode 11 (triangle) and period P > 0, the count runs 0 up to P and back down to 0, a cycle of 2P advances. The flag sets when the count reaches 0 while descending.
- R8: In up or triangle mode with period 0, the count stays at 0 and the flag is not set.
- R9: Writing control with bit 2 = 1 zeroes the count, restarts the divider and selects upward counting. The other fields of that same write take effect, and bit 2 reads back as 0.
- R10: Control bit 0 is the pending flag. It stays set until software writes it, and a write of 0 acknowledges it without touching the count. `irq` = flag AND bit 1. A hardware set in the same cycle as a write takes priority over that write.
- R11: Bus addresses: 0 is control, 1 is count (readable and writable), 2 is period, and 3 reads 0. Control bits 15:10 and 3 read 0. Count and period are zero-extended to 16 bits, and writes keep only the low CNT_W bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_ext | input | 1 | Source 0 clock enable |
| tick_aux | input | 1 | Source 1 clock enable |
| tick_sys | input | 1 | Source 2 clock enable |
| tick_ext_n | input | 1 | Source 3 clock enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with CNT_W = 4. With that width the continuous-mode wrap at 15 takes only 16 advances, even behind the divide-by-8 setting. This makes a full sweep practical: every mode, every divider code, several periods, and each of the four sources taken in turn, with the count and flag predicted from the tick number by modular arithmetic. Directed sequences then cover the stop hold, a zero period, a count above the period, and a restart that lands in the middle of a divider phase or on a descending slope.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [1:0] {
        MODE_STOP = 2'd0,
        MODE_UP   = 2'd1,
        MODE_CONT = 2'd2,
        MODE_TRI  = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } cnt_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_COUNT  = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;

    localparam int B_FLAG    = 0;
    localparam int B_IE      = 1;
    localparam int B_RESTART = 2;
    localparam int B_MODE_LO = 4;
    localparam int B_DIV_LO  = 6;
    localparam int B_SRC_LO  = 8;

    localparam int DIV_W = 3;
endpackage

// File: rtl/mmt_prescale.sv
module mmt_prescale
    import mmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] src_en,
    input  logic [1:0] src_sel,
    input  logic [1:0] div_sel,
    input  logic       restart,
    output logic       cnt_tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_max;
    logic             src_tick;

    always_comb begin
        src_tick = src_en[src_sel];
        unique case (div_sel)
            2'd0:    div_max = DIV_W'(0);
            2'd1:    div_max = DIV_W'(1);
            2'd2:    div_max = DIV_W'(3);
            default: div_max = DIV_W'(7);
        endcase
        cnt_tick = src_tick && (div_cnt >= div_max);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (restart) begin
            div_cnt <= '0;
        end else if (src_tick) begin
            if (div_cnt >= div_max) div_cnt <= '0;
            else                    div_cnt <= div_cnt + DIV_W'(1);
        end
    end

    // R9
    presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_cnt == '0));
endmodule

// File: rtl/mmt_core.sv
module mmt_core
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic [CNT_W-1:0] period,
    input  logic             cnt_tick,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] val;
        logic             down;
        logic             wrap;
    } step_t;

    cnt_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt_nx;
    step_t            stp;

    function automatic step_t advance(input mode_e md, input logic going_down,
                                      input logic [CNT_W-1:0] cv,
                                      input logic [CNT_W-1:0] pv);
        step_t s;
        s.val  = cv;
        s.down = 1'b0;
        s.wrap = 1'b0;
        case (md)
            MODE_UP: begin
                if (pv == '0)       s.val = '0;
                else if (cv >= pv) begin
                    s.val  = '0;
                    s.wrap = 1'b1;
                end else            s.val = cv + ONE;
            end
            MODE_CONT: begin
                if (cv == CNT_MAX) begin
                    s.val  = '0;
                    s.wrap = 1'b1;
                end else s.val = cv + ONE;
            end
            MODE_TRI: begin
                if (pv == '0) s.val = '0;
                else if (going_down || cv >= pv) begin
                    if (cv <= ONE) begin
                        s.val  = '0;
                        s.wrap = 1'b1;
                    end else begin
                        s.val  = cv - ONE;
                        s.down = 1'b1;
                    end
                end else s.val = cv + ONE;
            end
            default: s.val = cv;
        endcase
        return s;
    endfunction

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        wrap_evt = 1'b0;
        stp      = advance(mode, state == ST_FALL, cnt, period);
        if (clr) begin
            cnt_nx   = '0;
            state_nx = ST_RISE;
        end else if (load) begin
            cnt_nx = load_val;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (mode != MODE_STOP) begin
                        state_nx = ST_RISE;
                        if (cnt_tick) begin
                            cnt_nx   = stp.val;
                            state_nx = stp.down ? ST_FALL : ST_RISE;
                            wrap_evt = stp.wrap;
                        end
                    end
                end
                ST_RISE, ST_FALL: begin
                    if (mode == MODE_STOP) begin
                        state_nx = ST_IDLE;
                    end else begin
                        if (mode != MODE_TRI) state_nx = ST_RISE;
                        if (cnt_tick) begin
                            cnt_nx   = stp.val;
                            state_nx = stp.down ? ST_FALL : ST_RISE;
                            wrap_evt = stp.wrap;
                        end
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // R4
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !clr && !load) |=> $stable(cnt));

    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R6
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONT && cnt_tick && cnt == CNT_MAX && !clr && !load) |=> (cnt == '0));

    // R8
    zero_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_UP || mode == MODE_TRI) && period == '0 && cnt == '0 && !clr && !load)
        |=> (cnt == '0));
endmodule

// File: rtl/multimode_timer.sv
module multimode_timer
    import mmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        tick_ext,
    input  logic        tick_aux,
    input  logic        tick_sys,
    input  logic        tick_ext_n,
    output logic        irq
);
    logic [1:0]       src_sel;
    logic [1:0]       div_sel;
    mode_e            mode;
    logic             ie;
    logic             flag;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] cnt;
    logic             cnt_tick;
    logic             wrap_evt;
    logic             ctrl_wr;
    logic             clr;
    logic             load;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
    assign clr     = ctrl_wr && bus_wdata[B_RESTART];
    assign load    = bus_wr && (bus_addr == ADDR_COUNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_sel <= '0;
            div_sel <= '0;
            mode    <= MODE_STOP;
            ie      <= 1'b0;
            period  <= '0;
        end else begin
            if (ctrl_wr) begin
                src_sel <= bus_wdata[B_SRC_LO +: 2];
                div_sel <= bus_wdata[B_DIV_LO +: 2];
                mode    <= mode_e'(bus_wdata[B_MODE_LO +: 2]);
                ie      <= bus_wdata[B_IE];
            end
            if (bus_wr && bus_addr == ADDR_PERIOD) period <= bus_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap_evt) flag <= 1'b1;
        else if (ctrl_wr)  flag <= bus_wdata[B_FLAG];
    end

    assign irq = flag & ie;

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = {6'b0, src_sel, div_sel, 2'(mode), 2'b00, ie, flag};
            ADDR_COUNT:  bus_rdata = DATA_W'(cnt);
            ADDR_PERIOD: bus_rdata = DATA_W'(period);
            default:     bus_rdata = '0;
        endcase
    end

    mmt_prescale u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_en   ({tick_ext_n, tick_sys, tick_aux, tick_ext}),
        .src_sel  (src_sel),
        .div_sel  (div_sel),
        .restart  (clr),
        .cnt_tick (cnt_tick)
    );

    mmt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .period   (period),
        .cnt_tick (cnt_tick),
        .clr      (clr),
        .load     (load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .wrap_evt (wrap_evt)
    );

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(wrap_evt) || $past(ctrl_wr)));
endmodule

// File: tb/multimode_timer_tb.sv
module multimode_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;
    localparam int FULL       = 1 << CW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic [3:0]  ten;
    logic        irq;
    int          vectors = 0;
    int          fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    multimode_timer #(.CNT_W(CW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .tick_ext   (ten[0]),
        .tick_aux   (ten[1]),
        .tick_sys   (ten[2]),
        .tick_ext_n (ten[3]),
        .irq        (irq)
    );

    task automatic chk(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = 16'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    // one pulse on the selected source, then one cycle on all the others
    task automatic pulse(input int sel);
        @(negedge clk);
        ten = 4'(1 << sel);
        @(negedge clk);
        ten = ~4'(1 << sel);
        @(negedge clk);
        ten = 4'b0;
    endtask

    task automatic pulses(input int sel, input int n);
        for (int i = 0; i < n; i++) pulse(sel);
    endtask

    function automatic int cyc_len(input int m, input int p);
        if (m == 1) return p + 1;
        if (m == 2) return FULL;
        return 2 * p;
    endfunction

    function automatic int model(input int m, input int p, input int k);
        int r;
        r = k % cyc_len(m, p);
        if (m == 3 && r > p) return 2 * p - r;
        return r;
    endfunction

    function automatic int ctrl(input int src, input int dv, input int m,
                                input int rs, input int ie, input int fl);
        return (src << 8) | (dv << 6) | (m << 4) | (rs << 2) | (ie << 1) | fl;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int v;
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; ten = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 count", v, 0);
        rd(2, v); chk("R1 period", v, 0);
        chk("R1 irq", irq, 0);

        // R11 register map and field widths
        wr(0, 16'hFFFB);
        rd(0, v); chk("R11 ctrl readback", v, 16'h03F3);
        chk("R10 irq with flag and enable", irq, 1);
        wr(0, 0);
        chk("R10 irq after ack", irq, 0);
        wr(2, 16'hFFFF);
        rd(2, v); chk("R11 period width", v, FULL - 1);
        wr(1, 16'h1234);
        rd(1, v); chk("R11 count width", v, 4);
        rd(3, v); chk("R11 unused address", v, 0);

        // R4 stop mode holds
        wr(1, 5);
        wr(0, ctrl(1, 0, 0, 0, 0, 0));
        pulses(1, 4);
        rd(1, v); chk("R4 stop hold", v, 5);

        // R5 count above period returns to zero with flag
        wr(2, 3);
        wr(1, 9);
        wr(0, ctrl(1, 0, 1, 0, 0, 0));
        pulse(1);
        rd(1, v); chk("R5 above period", v, 0);
        rd(0, v); chk("R5 above period flag", v & 1, 1);

        // R8 period zero holds in up and triangle
        for (int m = 1; m <= 3; m += 2) begin
            wr(2, 0);
            wr(0, ctrl(1, 0, m, 1, 0, 0));
            pulses(1, 5);
            rd(1, v); chk("R8 zero period count", v, 0);
            rd(0, v); chk("R8 zero period flag", v & 1, 0);
        end

        // R9 restart resets the divider phase
        wr(2, 15);
        wr(0, ctrl(1, 2, 1, 1, 0, 0));
        pulses(1, 3);
        rd(1, v); chk("R3 divide by 4 before fourth tick", v, 0);
        wr(0, ctrl(1, 2, 1, 1, 0, 0));
        pulses(1, 3);
        rd(1, v); chk("R9 divider restarted", v, 0);
        pulse(1);
        rd(1, v); chk("R9 first advance on fourth tick", v, 1);

        // R9 restart selects upward counting
        wr(2, 6);
        wr(0, ctrl(1, 0, 3, 1, 0, 0));
        pulses(1, 8);
        rd(1, v); chk("R7 descending", v, 4);
        wr(0, ctrl(1, 0, 3, 1, 0, 0));
        pulses(1, 2);
        rd(1, v); chk("R9 direction up after restart", v, 2);
        rd(0, v); chk("R9 no flag after restart", v & 1, 0);

        // R10 acknowledge keeps the count
        wr(0, ctrl(1, 0, 2, 1, 1, 0));
        pulses(1, FULL);
        rd(1, v); chk("R6 wrap", v, 0);
        chk("R10 irq raised", irq, 1);
        wr(0, ctrl(1, 0, 2, 0, 1, 0));
        chk("R10 irq cleared by ack", irq, 0);
        rd(0, v); chk("R10 flag cleared by ack", v & 1, 0);
        pulse(1);
        rd(1, v); chk("R10 count kept after ack", v, 1);

        // sweep: R2 sources, R3 dividers, R5 R6 R7 modes
        for (int m = 1; m <= 3; m++) begin
            for (int d = 0; d < 4; d++) begin
                for (int pi = 0; pi < 3; pi++) begin
                    int p, src, dv, nt, k, cl, ie;
                    string tag;
                    p   = (pi == 0) ? 1 : ((pi == 1) ? 3 : 6);
                    src = (m + d + pi) % 4;
                    dv  = 1 << d;
                    ie  = d % 2;
                    cl  = cyc_len(m, p);
                    tag = (m == 1) ? "R5 up R3 R2" : ((m == 2) ? "R6 continuous R3 R2" : "R7 triangle R3 R2");
                    if (!(m == 2 && pi > 0)) begin
                        wr(2, p);
                        wr(0, ctrl(src, d, m, 1, ie, 0));
                        rd(1, v); chk("R9 restart count", v, 0);
                        nt = (m == 2) ? (cl * dv + dv + 1) : (2 * cl * dv + 1);
                        for (int n = 1; n <= nt; n++) begin
                            pulse(src);
                            k = n / dv;
                            rd(1, v); chk(tag, v, model(m, p, k));
                            rd(0, v); chk({tag, " flag"}, v & 1, (k >= cl) ? 1 : 0);
                            chk("R10 irq gating", irq, (k >= cl && ie == 1) ? 1 : 0);
                        end
                    end
                end
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule